// File: doc/BRIEF.md
# Command Readiness Gate for a DLL-Clocked Memory

This block holds off read and write commands to a memory device until the device's input clock and its delay-locked loop have settled. It runs on a free-running reference clock. It watches the device input clock and the DLL enable input, and it raises a ready flag only when two separate conditions both hold.

The first condition is a power-up settling time. The input clock must run without stopping for a fixed time, and this is needed only once after reset. The second condition is a lock interval, counted in input-clock rising edges. The lock interval starts again every time the DLL is reset. A DLL reset happens when the enable input goes low, or when the input clock stays quiet for longer than a stop threshold.

All timing thresholds are given in nanoseconds and converted to reference-clock cycles at elaboration. Commands presented while the gate is not ready are dropped and flagged. Commands presented while it is ready are forwarded one cycle later.

Top module: `dll_ready_gate`

## Requirements
- R1: While rst_ni is low and right after it is released, ready_o, cmd_valid_o and cmd_err_o are 0, and the input clock is treated as stopped until its first rising edge is seen.
- R2: A rising edge of dev_clk_i is counted at the third rising edge of ref_clk_i after it. The lock count goes up by one per counted edge, stops at LOCK_CYC, and the DLL counts as locked when the count equals LOCK_CYC.
- R3: The input clock counts as stopped once STOP_CYC = ceil(STOP_NS*REF_MHZ/1000) reference cycles pass in a row with no counted edge. The first counted edge after that clears the stopped state.
- R4: A DLL reset is active whenever the synchronized enable is low or the clock is stopped. A change on dll_en_i reaches the synchronized enable at the second reference edge after it. While a DLL reset is active the lock count is cleared, and ready_o is 0 in that same cycle.
- R5: The power-up interval completes after INIT_CYC = ceil(INIT_NS*REF_MHZ/1000) reference cycles in a row with the clock not stopped. If the clock stops before completion, the count starts again from zero.
- R6: Once the power-up interval has completed, it stays complete until rst_ni. A later DLL reset requires only a new lock interval.
- R7: ready_o is 1 exactly when the power-up interval is complete, the DLL is locked, and no DLL reset is active.
- R8: A command (cmd_valid_i=1) sampled while ready_o=1 gives cmd_valid_o=1 in the next cycle, with cmd_data_o equal to its data. cmd_data_o keeps the last forwarded value otherwise.
- R9: A command sampled while ready_o=0 is not forwarded. Instead, cmd_err_o is 1 for the next cycle only. With no command, both cmd_valid_o and cmd_err_o are 0 in the next cycle.
- R10: A pause in dev_clk_i shorter than the stop threshold leaves the lock count, the power-up interval and ready_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_clk_i | input | 1 | Device input clock being monitored |
| dll_en_i | input | 1 | DLL enable, asynchronous, low resets the DLL |
| cmd_valid_i | input | 1 | Command request, reference domain |
| cmd_data_i | input | CMD_W | Command payload |
| cmd_valid_o | output | 1 | Forwarded command strobe |
| cmd_data_o | output | CMD_W | Forwarded command payload |
| cmd_err_o | output | 1 | One-cycle pulse for a rejected command |
| ready_o | output | 1 | Device may accept commands |

## Verification
The input clock is driven in four patterns. A steady run from cold shows the lock count and the power-up time working together. A long stop before the power-up time has elapsed shows that the power-up count restarts. A short pause that stays under the threshold shows that brief gaps are ignored. A long stop after ready shows that a clock stop resets the DLL without repeating the power-up time. A low pulse on the enable input, with the clock running, separates the enable path from the clock-stop path. Random command traffic runs through all phases, so that forwarding and rejection are both checked against the exact cycle in which ready changes.

// File: rtl/drg_pkg.sv
package drg_pkg;
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/drg_sync.sv
module drg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[STAGES-2:0], d_i};
  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/drg_clk_sense.sv
module drg_clk_sense #(
  parameter int STOP_CYC = 15
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic dev_clk_i,
  output logic edge_o,
  output logic stop_o
);
  localparam int IW = $clog2(STOP_CYC + 1);

  logic          tgl_q;
  logic [2:0]    sq;
  logic [IW-1:0] idle_q;

  // one toggle per device rising edge, carried across as a level
  always_ff @(posedge dev_clk_i or negedge rst_ni)
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[1:0], tgl_q};

  assign edge_o = sq[2] ^ sq[1];

  // starts saturated: clock treated as stopped until first edge
  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni)                  idle_q <= IW'(STOP_CYC);
    else if (edge_o)              idle_q <= '0;
    else if (idle_q != IW'(STOP_CYC)) idle_q <= idle_q + 1'b1;

  assign stop_o = (idle_q == IW'(STOP_CYC));
endmodule

// File: rtl/drg_lock_ctr.sv
module drg_lock_ctr #(
  parameter int LOCK_CYC = 2048,
  localparam int LW = $clog2(LOCK_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [LW-1:0] cnt_o,
  output logic          locked_o
);
  logic [LW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              cnt_q <= '0;
    else if (clear_i)                         cnt_q <= '0;
    else if (step_i && cnt_q != LW'(LOCK_CYC)) cnt_q <= cnt_q + 1'b1;
  assign cnt_o    = cnt_q;
  assign locked_o = (cnt_q == LW'(LOCK_CYC));
endmodule

// File: rtl/drg_init_timer.sv
module drg_init_timer #(
  parameter int INIT_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(INIT_CYC + 1);
  logic [CW-1:0] cnt_q;
  // saturates at INIT_CYC and never leaves it: one-shot
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q != CW'(INIT_CYC))  cnt_q <= run_i ? cnt_q + 1'b1 : '0;
  assign done_o = (cnt_q == CW'(INIT_CYC));
endmodule

// File: rtl/drg_cmd_gate.sv
module drg_cmd_gate #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             valid_i,
  input  logic [CMD_W-1:0] data_i,
  output logic             valid_o,
  output logic [CMD_W-1:0] data_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i & open_i;
      err_o   <= valid_i & ~open_i;
      if (valid_i && open_i) data_o <= data_i;
    end
endmodule

// File: rtl/dll_ready_gate.sv
module dll_ready_gate
  import drg_pkg::*;
#(
  parameter int REF_MHZ  = 500,
  parameter int INIT_NS  = 20000,
  parameter int STOP_NS  = 30,
  parameter int LOCK_CYC = 2048,
  parameter int CMD_W    = 8
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             dev_clk_i,
  input  logic             dll_en_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_data_o,
  output logic             cmd_err_o,
  output logic             ready_o
);
  localparam int INIT_CYC = ns_to_cyc(INIT_NS, REF_MHZ);
  localparam int STOP_CYC = ns_to_cyc(STOP_NS, REF_MHZ);
  localparam int LW       = $clog2(LOCK_CYC + 1);

  logic          en_sync, dev_edge, clk_stop, dll_rst;
  logic          lock_done, init_done;
  logic [LW-1:0] lock_cnt;

  drg_sync #(.STAGES(2)) u_en_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(dll_en_i), .q_o(en_sync)
  );

  drg_clk_sense #(.STOP_CYC(STOP_CYC)) u_sense (
    .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .dev_clk_i(dev_clk_i),
    .edge_o(dev_edge), .stop_o(clk_stop)
  );

  assign dll_rst = ~en_sync | clk_stop;

  drg_lock_ctr #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .clear_i(dll_rst), .step_i(dev_edge),
    .cnt_o(lock_cnt), .locked_o(lock_done)
  );

  drg_init_timer #(.INIT_CYC(INIT_CYC)) u_init (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .run_i(~clk_stop), .done_o(init_done)
  );

  assign ready_o = init_done & lock_done & ~dll_rst;

  drg_cmd_gate #(.CMD_W(CMD_W)) u_gate (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .open_i(ready_o),
    .valid_i(cmd_valid_i), .data_i(cmd_data_i),
    .valid_o(cmd_valid_o), .data_o(cmd_data_o), .err_o(cmd_err_o)
  );
endmodule

// File: rtl/dll_ready_gate_chk.sv
module dll_ready_gate_chk #(
  parameter int LW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_valid_o,
  input logic          cmd_err_o,
  input logic          ready_o,
  input logic          dll_rst,
  input logic          init_done,
  input logic          lock_done,
  input logic [LW-1:0] lock_cnt
);
  // R8
  fwd_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && ready_o |=> cmd_valid_o && !cmd_err_o);
  // R9
  reject_when_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !ready_o |=> cmd_err_o && !cmd_valid_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !cmd_valid_o && !cmd_err_o);
  // R4
  rst_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_rst |-> !ready_o);
  // R6
  init_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done |=> init_done);
  // R2
  lock_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dll_rst |=> (lock_cnt == $past(lock_cnt)) || (lock_cnt == $past(lock_cnt) + 1'b1));
  // R2
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_done && !dll_rst |=> lock_done);
  // R7
  ready_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> init_done && lock_done);
endmodule

bind dll_ready_gate dll_ready_gate_chk #(.LW(LW)) u_chk (
  .clk_i(ref_clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_valid_o(cmd_valid_o), .cmd_err_o(cmd_err_o), .ready_o(ready_o),
  .dll_rst(dll_rst), .init_done(init_done), .lock_done(lock_done),
  .lock_cnt(lock_cnt)
);

// File: tb/sim_dll_ready_gate.sv
`timescale 1ns/1ps
module sim_dll_ready_gate;
  localparam int REF_MHZ = 50;
  localparam int INIT_NS = 4000;
  localparam int STOP_NS = 200;
  localparam int LOCK    = 40;
  localparam int CW      = 8;
  localparam int STOP    = (STOP_NS * REF_MHZ + 999) / 1000;
  localparam int INIT    = (INIT_NS * REF_MHZ + 999) / 1000;

  logic clk = 0, rst_n = 0, dev_clk = 0, dll_en = 0, cmd_v = 0;
  logic [CW-1:0] cmd_d = '0;
  logic vo, err, rdy;
  logic [CW-1:0] dout;

  int tests = 0, fails = 0;
  bit dev_run = 0, dev_pulse = 0, done = 0;
  int div_c = 0;

  always #10 clk = ~clk;

  dll_ready_gate #(.REF_MHZ(REF_MHZ), .INIT_NS(INIT_NS), .STOP_NS(STOP_NS),
                   .LOCK_CYC(LOCK), .CMD_W(CW)) u0 (
    .ref_clk_i(clk), .rst_ni(rst_n), .dev_clk_i(dev_clk), .dll_en_i(dll_en),
    .cmd_valid_i(cmd_v), .cmd_data_i(cmd_d), .cmd_valid_o(vo),
    .cmd_data_o(dout), .cmd_err_o(err), .ready_o(rdy)
  );

  // device clock: period 4 reference cycles, edges placed at ref negedges
  always @(negedge clk) if (dev_run) begin
    div_c++;
    if (div_c == 2) begin
      div_c = 0;
      dev_clk = ~dev_clk;
      if (dev_clk) dev_pulse = 1;
    end
  end

  // behavioural reference model
  int m_idle, m_lock, m_init;
  bit p0, p1, e0, e1, x_vo, x_err, x_rdy;
  logic [CW-1:0] x_data;

  function automatic bit rdy_of(int ini, int lk, int idl, bit en);
    return (ini == INIT) && (lk == LOCK) && en && (idl != STOP);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle = STOP; m_lock = 0; m_init = 0;
      p0 = 0; p1 = 0; e0 = 0; e1 = 0; dev_pulse = 0;
      x_vo = 0; x_err = 0; x_rdy = 0; x_data = '0;
    end else begin
      bit edge_now, stop_now, rdy_now;
      edge_now = p1;
      stop_now = (m_idle == STOP);
      rdy_now  = rdy_of(m_init, m_lock, m_idle, e1);
      x_vo  = cmd_v && rdy_now;
      x_err = cmd_v && !rdy_now;
      if (x_vo) x_data = cmd_d;
      if (m_init != INIT) m_init = stop_now ? 0 : m_init + 1;
      if (!e1 || stop_now) m_lock = 0;
      else if (edge_now && m_lock < LOCK) m_lock++;
      if (edge_now) m_idle = 0;
      else if (m_idle < STOP) m_idle++;
      p1 = p0; p0 = dev_pulse; dev_pulse = 0;
      e1 = e0; e0 = dll_en;
      x_rdy = rdy_of(m_init, m_lock, m_idle, e1);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(rdy == x_rdy, "R7 ready (R2 R3 R4 R5)", rdy, x_rdy);
    chk(vo == x_vo, "R8 forward", vo, x_vo);
    chk(err == x_err, "R9 reject", err, x_err);
    if (x_vo) chk(dout == x_data, "R8 data", dout, x_data);
  end

  // random command traffic driven away from the active edge
  always @(negedge clk) begin
    cmd_v = rst_n ? 1'($urandom % 2) : 1'b0;
    cmd_d = CW'($urandom);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    #1;
    chk(rdy == 0 && vo == 0 && err == 0, "R1 reset outputs", rdy, 0);
    rst_n = 1;
    cyc(2);
    chk(rdy == 0, "R1 after release", rdy, 0);
    cyc(10);
    dll_en = 1;
    dev_run = 1;
    cyc(60);
    // R5: long stop before power-up completes restarts the interval
    dev_run = 0;
    cyc(20);
    dev_run = 1;
    cyc(180);
    chk(rdy == 0, "R5 restart after stop", rdy, 0);
    cyc(60);
    chk(rdy == 1, "R7 ready after init and lock", rdy, 1);
    // R4: enable low pulse
    dll_en = 0;
    cyc(3);
    chk(rdy == 0, "R4 enable low drops ready", rdy, 0);
    cyc(3);
    dll_en = 1;
    // R6: relock without repeating power-up time
    cyc(175);
    chk(rdy == 1, "R6 relock only", rdy, 1);
    // R10: short pause under threshold
    dev_run = 0;
    cyc(4);
    dev_run = 1;
    cyc(12);
    chk(rdy == 1, "R10 short pause ignored", rdy, 1);
    // R3: long stop resets DLL
    dev_run = 0;
    cyc(30);
    chk(rdy == 0, "R3 stop drops ready", rdy, 0);
    dev_run = 1;
    cyc(180);
    chk(rdy == 1, "R6 ready after stop relock", rdy, 1);
    cyc(20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule